// File: doc/BRIEF.md
# SD Card SPI-Mode Command Transaction Engine

This block runs one complete command exchange with a memory card in SPI mode. A host sequencer gives it a 6-bit command index, a 32-bit argument, a check byte and two options: whether a 4-byte trailer follows the status byte, and whether chip select should stay low afterwards. The engine drives the byte-exchange port of an external SPI shifter one byte at a time. It pulls chip select low and sends the six-byte command frame. It then clocks fill bytes until the card answers with a status byte whose top bit is clear, or until a poll budget runs out.

Once the status byte arrives, the engine can collect a trailer word, for example an operating-conditions word or a voltage-check echo. On normal completion it raises chip select and sends one padding byte. In hold mode chip select stays low after the status byte (and trailer, if requested), so that a data phase run by other logic can follow. A pulse on `hold_end` then closes the transaction. Results are the status byte, the trailer word and a timeout flag, and a one-cycle `done` pulse marks them valid.

Top module: `sdspi_cmd_engine`

## Requirements
- R1: The frame bytes go out in this order. The first is 0x40 OR'd with the command index, so it carries start bits 01 in bits 7:6. Next come argument bytes [31:24], [23:16], [15:8] and [7:0]. The last is the supplied check byte with bit 0 forced to 1.
- R2: Accepting a request (`req_valid` while `req_ready`) drives `cs_n` low from the next cycle on. While a transaction is in progress, `req_ready` is 0 and `req_valid` has no effect on the byte stream.
- R3: After the frame, the engine sends 0xFF in every poll byte. The first received byte with bit 7 equal to 0 is returned on `r1` and ends polling. Its bits 0 to 6 are: idle, erase reset, illegal command, command check error, erase sequence error, address error, parameter error.
- R4: If POLL_LIMIT poll bytes in a row all have bit 7 set, the engine reports a timeout. It sets `timed_out`=1 and `r1`=0xFF, skips any trailer, raises `cs_n` and sends one 0xFF pad byte.
- R5: When `req_tail`=1, the engine receives four more bytes after a valid status byte, with `cs_n` low and 0xFF sent each time. It returns them on `tail_word` with the first byte in bits 31:24. Otherwise `tail_word` is 0.
- R6: On normal completion `cs_n` goes high before exactly one 0xFF pad byte is sent. `done` pulses for one cycle after that byte completes, and `req_ready` returns to 1.
- R7: In hold mode (`req_hold`=1), `done` pulses once after the status byte (and trailer). `cs_n` then stays low and no byte is started until `hold_end`. After `hold_end`, `cs_n` rises and one 0xFF pad byte is sent, with no second `done`.
- R8: A timeout in hold mode releases `cs_n` and pads exactly as in R4, with a single `done` after the pad byte.
- R9: After reset: `cs_n`=1, `req_ready`=1, `xfer_start`=0, `done`=0, `timed_out`=0.
- R10: `xfer_start` is a single-cycle pulse. No new byte starts before `xfer_done` has returned the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_crc | input | 8 | Check byte; bit 0 is forced to 1 on the wire |
| req_tail | input | 1 | Collect a 4-byte trailer after the status byte |
| req_hold | input | 1 | Keep chip select low after the status byte |
| hold_end | input | 1 | Ends a held transaction |
| xfer_start | output | 1 | Starts one byte exchange on the shifter |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | Shifter has finished the exchange |
| xfer_rx | input | 8 | Byte received in that exchange |
| cs_n | output | 1 | Card chip select, active low |
| done | output | 1 | Results valid (one-cycle pulse) |
| r1 | output | 8 | Status byte, 0xFF on timeout |
| tail_word | output | 32 | Trailer word |
| timed_out | output | 1 | Poll budget exhausted |

## Verification
A corrupted byte index or state shows up on the very next byte sent. A scoreboard compares every transmitted byte, together with the level of chip select at that moment, against the sequence the requirements predict. A poll counter that is off by one shows up as one byte too many or too few in the timeout case. A mistracked hold flag shows up as a pad byte or a `done` pulse during the quiet window, or as a missing one after `hold_end`. Status, trailer and timeout values are checked in the cycle that `done` is high.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_POLL,
    ST_TAIL,
    ST_HOLD,
    ST_PAD
  } eng_state_t;

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [1:0] START_BITS = 2'b01;
endpackage

// File: rtl/sdspi_frame_mux.sv
module sdspi_frame_mux #(
  parameter int IDX_W    = 6,
  parameter int ARG_BYTES = 4,
  parameter int SEL_W    = 3
) (
  input  logic [IDX_W-1:0]       cmd_index,
  input  logic [ARG_BYTES*8-1:0] cmd_arg,
  input  logic [7:0]             cmd_crc,
  input  logic [SEL_W-1:0]       sel,
  output logic [7:0]             byte_out
);
  import sdspi_pkg::*;
  localparam int NBYTES = ARG_BYTES + 2;

  logic [7:0] frame [NBYTES];

  assign frame[0] = {START_BITS, cmd_index};
  for (genvar g = 0; g < ARG_BYTES; g++) begin : g_arg
    assign frame[g+1] = cmd_arg[(ARG_BYTES-1-g)*8 +: 8];
  end
  assign frame[NBYTES-1] = {cmd_crc[7:1], 1'b1};

  always_comb begin
    byte_out = FILL_BYTE;
    for (int i = 0; i < NBYTES; i++) begin
      if (sel == SEL_W'(i)) byte_out = frame[i];
    end
  end
endmodule

// File: rtl/sdspi_poll_ctr.sv
module sdspi_poll_ctr #(
  parameter int POLL_LIMIT = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_last
);
  localparam int CW = $clog2(POLL_LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && !at_last) cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == CW'(POLL_LIMIT - 1));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(POLL_LIMIT));
endmodule

// File: rtl/sdspi_tail_sr.sv
module sdspi_tail_sr #(
  parameter int NBYTES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                shift,
  input  logic [7:0]          din,
  output logic [NBYTES*8-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clr) word <= '0;
    else if (shift) word <= {word[NBYTES*8-9:0], din};
  end
endmodule

// File: rtl/sdspi_cmd_engine.sv
module sdspi_cmd_engine #(
  parameter int POLL_LIMIT = 5000,
  parameter int ARG_BYTES  = 4,
  parameter int TAIL_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [5:0]              req_index,
  input  logic [ARG_BYTES*8-1:0]  req_arg,
  input  logic [7:0]              req_crc,
  input  logic                    req_tail,
  input  logic                    req_hold,
  input  logic                    hold_end,
  output logic                    xfer_start,
  output logic [7:0]              xfer_tx,
  input  logic                    xfer_done,
  input  logic [7:0]              xfer_rx,
  output logic                    cs_n,
  output logic                    done,
  output logic [7:0]              r1,
  output logic [TAIL_BYTES*8-1:0] tail_word,
  output logic                    timed_out
);
  import sdspi_pkg::*;

  localparam int FRAME_BYTES = ARG_BYTES + 2;
  localparam int CNT_MAX     = (FRAME_BYTES > TAIL_BYTES) ? FRAME_BYTES : TAIL_BYTES;
  localparam int IW          = $clog2(CNT_MAX);

  eng_state_t              state;
  logic [IW-1:0]           idx;
  logic                    pending;
  logic                    hold_q;
  logic                    tail_q;
  logic [5:0]              idx_q;
  logic [ARG_BYTES*8-1:0]  arg_q;
  logic [7:0]              crc_q;
  logic [7:0]              frame_byte;
  logic                    poll_last;
  logic                    accept;
  logic                    byte_back;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign byte_back = pending && xfer_done;

  sdspi_frame_mux #(.IDX_W(6), .ARG_BYTES(ARG_BYTES), .SEL_W(IW)) u_mux (
    .cmd_index(idx_q), .cmd_arg(arg_q), .cmd_crc(crc_q),
    .sel(idx), .byte_out(frame_byte)
  );

  sdspi_poll_ctr #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst(rst), .clr(state == ST_IDLE),
    .inc((state == ST_POLL) && byte_back && xfer_rx[7]),
    .at_last(poll_last)
  );

  sdspi_tail_sr #(.NBYTES(TAIL_BYTES)) u_tail (
    .clk(clk), .rst(rst), .clr(accept),
    .shift((state == ST_TAIL) && byte_back),
    .din(xfer_rx), .word(tail_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      pending    <= 1'b0;
      hold_q     <= 1'b0;
      tail_q     <= 1'b0;
      idx_q      <= '0;
      arg_q      <= '0;
      crc_q      <= '0;
      cs_n       <= 1'b1;
      xfer_start <= 1'b0;
      xfer_tx    <= FILL_BYTE;
      done       <= 1'b0;
      r1         <= FILL_BYTE;
      timed_out  <= 1'b0;
    end else begin
      xfer_start <= 1'b0;
      done       <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            idx_q     <= req_index;
            arg_q     <= req_arg;
            crc_q     <= req_crc;
            hold_q    <= req_hold;
            tail_q    <= req_tail;
            cs_n      <= 1'b0;
            idx       <= '0;
            pending   <= 1'b0;
            timed_out <= 1'b0;
            r1        <= FILL_BYTE;
            state     <= ST_SEND;
          end
        end
        ST_HOLD: begin
          if (hold_end) begin
            cs_n  <= 1'b1;
            state <= ST_PAD;
          end
        end
        default: begin
          if (!pending) begin
            xfer_start <= 1'b1;
            xfer_tx    <= (state == ST_SEND) ? frame_byte : FILL_BYTE;
            pending    <= 1'b1;
          end else if (xfer_done) begin
            pending <= 1'b0;
            case (state)
              ST_SEND: begin
                if (idx == IW'(FRAME_BYTES - 1)) state <= ST_POLL;
                else idx <= idx + 1'b1;
              end
              ST_POLL: begin
                if (!xfer_rx[7]) begin
                  r1 <= xfer_rx;
                  if (tail_q) begin
                    idx   <= '0;
                    state <= ST_TAIL;
                  end else if (hold_q) begin
                    done  <= 1'b1;
                    state <= ST_HOLD;
                  end else begin
                    cs_n  <= 1'b1;
                    state <= ST_PAD;
                  end
                end else if (poll_last) begin
                  timed_out <= 1'b1;
                  hold_q    <= 1'b0;
                  cs_n      <= 1'b1;
                  state     <= ST_PAD;
                end
              end
              ST_TAIL: begin
                if (idx == IW'(TAIL_BYTES - 1)) begin
                  if (hold_q) begin
                    done  <= 1'b1;
                    state <= ST_HOLD;
                  end else begin
                    cs_n  <= 1'b1;
                    state <= ST_PAD;
                  end
                end else begin
                  idx <= idx + 1'b1;
                end
              end
              ST_PAD: begin
                done  <= !hold_q;
                state <= ST_IDLE;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R2
  accept_cs_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !cs_n);
  // R3
  r1_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !timed_out) |-> !r1[7]);
  // R4
  timeout_r1_chk: assert property (@(posedge clk) disable iff (rst)
    (done && timed_out) |-> (r1 == FILL_BYTE && cs_n));
  // R6
  pad_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && state == ST_PAD) |-> cs_n);
  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |-> (!xfer_start && !cs_n));
  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);
endmodule

// File: tb/tb_sdspi_cmd_engine.sv
module tb_sdspi_cmd_engine;
  localparam int LIMIT = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_index = '0;
  logic [31:0] req_arg = '0;
  logic [7:0]  req_crc = '0;
  logic        req_tail = 1'b0;
  logic        req_hold = 1'b0;
  logic        hold_end = 1'b0;
  logic        xfer_start;
  logic [7:0]  xfer_tx;
  logic        xfer_done = 1'b0;
  logic [7:0]  xfer_rx = 8'hFF;
  logic        cs_n;
  logic        done;
  logic [7:0]  r1;
  logic [31:0] tail_word;
  logic        timed_out;

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int done_cnt = 0;
  string cur_req = "R1";

  logic [7:0] rxq[$];
  logic [7:0] exp_b[$];
  logic       exp_cs[$];

  always #10 clk = ~clk;

  sdspi_cmd_engine #(.POLL_LIMIT(LIMIT)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_arg(req_arg), .req_crc(req_crc),
    .req_tail(req_tail), .req_hold(req_hold), .hold_end(hold_end),
    .xfer_start(xfer_start), .xfer_tx(xfer_tx), .xfer_done(xfer_done),
    .xfer_rx(xfer_rx), .cs_n(cs_n), .done(done), .r1(r1),
    .tail_word(tail_word), .timed_out(timed_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Shifter model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
      if (xfer_start) begin
        logic [7:0] rb;
        sent++;
        if (exp_b.size() == 0) begin
          checks++; errors++;
          $display("FAIL %s: unexpected byte %h cs %b, expected none", cur_req, xfer_tx, cs_n);
        end else begin
          logic [7:0] eb;
          logic ec;
          eb = exp_b.pop_front();
          ec = exp_cs.pop_front();
          check({cur_req, " byte"}, {24'd0, xfer_tx}, {24'd0, eb});
          check({cur_req, " cs_n"}, {31'd0, cs_n}, {31'd0, ec});
        end
        rb = (rxq.size() > 0) ? rxq.pop_front() : 8'hFF;
        @(negedge clk);
        if (done) done_cnt++;
        xfer_rx = rb;
        xfer_done = 1'b1;
        @(negedge clk);
        if (done) done_cnt++;
        xfer_done = 1'b0;
      end
    end
  end

  task automatic push(input logic [7:0] b, input logic c);
    exp_b.push_back(b);
    exp_cs.push_back(c);
  endtask

  task automatic run_cmd(input string req, input logic [5:0] ci, input logic [31:0] ca,
                         input logic [7:0] cc, input logic tl, input logic hd,
                         input int busy, input logic [7:0] rv, input logic [31:0] tw,
                         input logic tmo, input logic intrude);
    int guard;
    int d0;
    int s0;
    cur_req = req;
    // expected transmitted stream (R1, R3, R5, R6)
    push({2'b01, ci}, 1'b0);
    for (int k = 0; k < 4; k++) push(ca[(3-k)*8 +: 8], 1'b0);
    push({cc[7:1], 1'b1}, 1'b0);
    for (int k = 0; k < (tmo ? LIMIT : busy + 1); k++) push(8'hFF, 1'b0);
    if (!tmo && tl) for (int k = 0; k < 4; k++) push(8'hFF, 1'b0);
    if (tmo || !hd) push(8'hFF, 1'b1);
    // card replies
    for (int k = 0; k < 6 + busy; k++) rxq.push_back(8'hFF);
    if (!tmo) begin
      rxq.push_back(rv);
      if (tl) for (int k = 0; k < 4; k++) rxq.push_back(tw[(3-k)*8 +: 8]);
    end
    while (!req_ready) @(negedge clk);
    req_index = ci; req_arg = ca; req_crc = cc; req_tail = tl; req_hold = hd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " cs_n low after accept (R2)"}, {31'd0, cs_n}, 32'd0);
    if (intrude) begin
      repeat (3) @(negedge clk);
      check("R2 ready low while busy", {31'd0, req_ready}, 32'd0);
      req_index = 6'h2A; req_arg = 32'hDEADBEEF; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    guard = 0;
    while (!done && guard < 30000) begin @(negedge clk); guard++; end
    check({req, " done seen"}, {31'd0, done}, 32'd1);
    check({req, " r1"}, {24'd0, r1}, tmo ? 32'hFF : {24'd0, rv});
    check({req, " tail word (R5)"}, tail_word, (tl && !tmo) ? tw : 32'd0);
    check({req, " timeout flag"}, {31'd0, timed_out}, {31'd0, tmo});
    if (hd && !tmo) begin
      d0 = done_cnt;
      s0 = sent;
      repeat (12) @(negedge clk);
      check("R7 no byte while held", sent, s0);
      check("R7 cs_n low while held", {31'd0, cs_n}, 32'd0);
      push(8'hFF, 1'b1);
      hold_end = 1'b1;
      @(negedge clk);
      hold_end = 1'b0;
      guard = 0;
      while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
      repeat (3) @(negedge clk);
      check("R7 no second done", done_cnt, d0);
    end else begin
      @(negedge clk);
      check({req, " ready after done (R6)"}, {31'd0, req_ready}, 32'd1);
    end
    check({req, " stream complete"}, exp_b.size(), 32'd0);
    check({req, " cs_n idle high"}, {31'd0, cs_n}, 32'd1);
    rxq.delete();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 cs_n", {31'd0, cs_n}, 32'd1);
    check("R9 ready", {31'd0, req_ready}, 32'd1);
    check("R9 xfer_start", {31'd0, xfer_start}, 32'd0);
    check("R9 done", {31'd0, done}, 32'd0);
    check("R9 timed_out", {31'd0, timed_out}, 32'd0);

    // R1 R3 R6: reset command, answer after two busy bytes
    run_cmd("R1", 6'd0, 32'd0, 8'h95, 1'b0, 1'b0, 2, 8'h01, 32'd0, 1'b0, 1'b0);
    // R1: check byte bit 0 forced, argument order
    run_cmd("R1", 6'd17, 32'h1234_5678, 8'h94, 1'b0, 1'b0, 0, 8'h00, 32'd0, 1'b0, 1'b0);
    // R3: status with error bits (illegal command + idle)
    run_cmd("R3", 6'd55, 32'h0, 8'h95, 1'b0, 1'b0, 7, 8'h05, 32'd0, 1'b0, 1'b0);
    // R5: trailer collection
    run_cmd("R5", 6'd8, 32'h0000_01AA, 8'h87, 1'b1, 1'b0, 1, 8'h01, 32'h0000_01AA, 1'b0, 1'b0);
    run_cmd("R5", 6'd58, 32'h0, 8'h95, 1'b1, 1'b0, 0, 8'h00, 32'hC0FF_8000, 1'b0, 1'b0);
    // R2: request while busy is ignored
    run_cmd("R2", 6'd16, 32'h0000_0200, 8'h95, 1'b0, 1'b0, 4, 8'h00, 32'd0, 1'b0, 1'b1);
    // R7: hold mode, with and without trailer
    run_cmd("R7", 6'd9, 32'h0, 8'h95, 1'b0, 1'b1, 3, 8'h00, 32'd0, 1'b0, 1'b0);
    run_cmd("R7", 6'd58, 32'h0, 8'h95, 1'b1, 1'b1, 0, 8'h00, 32'h8765_4321, 1'b0, 1'b0);
    // R4: timeout; R8: timeout in hold mode
    run_cmd("R4", 6'd41, 32'h4000_0000, 8'h95, 1'b1, 1'b0, 0, 8'h00, 32'd0, 1'b1, 1'b0);
    run_cmd("R8", 6'd9, 32'h0, 8'h95, 1'b0, 1'b1, 0, 8'h00, 32'd0, 1'b1, 1'b0);
    // R10: engine usable after timeout, one byte at a time
    run_cmd("R10", 6'd13, 32'hA5A5_5A5A, 8'h01, 1'b0, 1'b0, 5, 8'h40, 32'd0, 1'b0, 1'b0);
    finish_run();
  end
endmodule